// File: doc/BRIEF.md
# Amplifier Reset and PWM-Validity Sequencer

This controller drives the active-low reset line of a class-D power stage. It holds that line low through power-up and through a bootstrap precharge interval that starts when the gate-drive supply is reported good. It releases reset only when the modulator says it is ready and the PWM stream it feeds the stage is switching at a period inside a set window. While the stage runs, the controller keeps watching the stream. A period outside the window, a stream that stops toggling, a supply dropping out or a power-down request pulls reset low within a cycle or two of the cause. The stream that is still running therefore never outlives the reset at shutdown.

When the power stage signals a protection event on its shutdown status line, the controller drives a recovery low pulse of programmable length on reset. It then releases reset again once the PWM is valid. Each such retry since the last power-down is counted. The fault that follows the last allowed retry parks the block in a locked state with reset low and a persistent-fault flag set. A half-bridge supply that reports good while the gate supply does not is a sequencing violation. It is latched and keeps reset low until a system reset.

The PWM input is synchronised with two flops. Its period is counted in reference-clock cycles from one rising edge to the next.

Top module: `amp_reset_sequencer`

## Requirements
- R1: After system reset, amp_rst_n, recovering, persist_fault and seq_error are all 0. Whenever gate_ok is sampled low, amp_rst_n is 0 after that clock edge.
- R2: With a valid PWM already present and mod_ready high, amp_rst_n rises exactly HOLD_CYCLES+2 clock cycles after gate_ok is first sampled high, and never earlier.
- R3: amp_rst_n is released only while mod_ready is high and the last GOOD_PERIODS consecutive rising-edge-to-rising-edge periods each lie within PERIOD_MIN to PERIOD_MAX cycles inclusive. mod_ready going low while running drops amp_rst_n on the next clock.
- R4: While running, a measured period outside the window pulls amp_rst_n low. Release resumes only after GOOD_PERIODS new in-window periods.
- R5: If the PWM input holds one level for more than STUCK_CYCLES cycles, the stream is invalid and amp_rst_n goes low. A valid stream later allows release again.
- R6: pd_req sampled high drives amp_rst_n low after that same clock edge. It stays low while pd_req is held.
- R7: pwr_ok high while gate_ok is low sets seq_error on the next clock. seq_error stays set until system reset, and amp_rst_n stays low while it is set.
- R8: stage_ok sampled low while running drops amp_rst_n on the next clock. recovering is then high for exactly RECOVER_CYCLES cycles. With valid PWM, amp_rst_n is low for exactly RECOVER_CYCLES+1 cycles in total before it is released again.
- R9: Of the stage faults since the last power-down, the first MAX_RETRIES each start a recovery. The next one sets persist_fault with amp_rst_n low until pd_req or loss of gate_ok. The retry count restarts from zero after such a power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock used for all timing and period measurement |
| rst_n | input | 1 | Asynchronous active-low system reset |
| gate_ok | input | 1 | Gate-drive supply good |
| pwr_ok | input | 1 | Half-bridge supply good |
| pwm_in | input | 1 | PWM stream sent to the power stage, asynchronous |
| mod_ready | input | 1 | Modulator initialised and streaming |
| pd_req | input | 1 | Power-down request |
| stage_ok | input | 1 | Power stage shutdown status, 0 means protection event |
| amp_rst_n | output | 1 | Active-low reset to the power stage, registered |
| recovering | output | 1 | High during the recovery low pulse |
| persist_fault | output | 1 | Retries used up, stage held in reset |
| seq_error | output | 1 | Sticky supply sequencing violation |

## Verification
A wrong state or counter value in this block shows only on amp_rst_n and the three flags. The bench measures latencies to the exact cycle: the hold release at HOLD_CYCLES+2, the recovery pulse of RECOVER_CYCLES+1 low cycles, and a one-cycle drop on power-down, supply loss or fault. A broken period window or stuck detector appears as a release that happens or fails to happen within a few PWM periods of the edge that decides it. A retry counter that is off by one appears on the fault that should or should not lock.

// File: rtl/amp_reset_sequencer.sv
module amp_reset_sequencer #(
  parameter int HOLD_CYCLES    = 100000,
  parameter int PERIOD_MIN     = 250,
  parameter int PERIOD_MAX     = 285,
  parameter int GOOD_PERIODS   = 4,
  parameter int STUCK_CYCLES   = 570,
  parameter int RECOVER_CYCLES = 1000,
  parameter int MAX_RETRIES    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_ok,
  input  logic pwr_ok,
  input  logic pwm_in,
  input  logic mod_ready,
  input  logic pd_req,
  input  logic stage_ok,
  output logic amp_rst_n,
  output logic recovering,
  output logic persist_fault,
  output logic seq_error
);

  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int CW = $clog2(PERIOD_MAX + 2);
  localparam int SW = $clog2(STUCK_CYCLES + 2);
  localparam int GW = $clog2(GOOD_PERIODS + 1);
  localparam int RW = $clog2(RECOVER_CYCLES + 1);
  localparam int TW = $clog2(MAX_RETRIES + 1);

  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);
  localparam logic [CW-1:0] PMIN      = CW'(PERIOD_MIN);
  localparam logic [CW-1:0] PMAX      = CW'(PERIOD_MAX);
  localparam logic [SW-1:0] STUCK_LIM = SW'(STUCK_CYCLES);
  localparam logic [GW-1:0] GOOD_N    = GW'(GOOD_PERIODS);
  localparam logic [RW-1:0] REC_LAST  = RW'(RECOVER_CYCLES - 1);
  localparam logic [TW-1:0] RETRY_N   = TW'(MAX_RETRIES);

  typedef enum logic [2:0] {S_OFF, S_HOLD, S_ARM, S_RUN, S_RECOVER, S_LOCK} seq_state_t;

  seq_state_t state, nstate;

  logic [2:0]    pwm_sh;
  logic [CW-1:0] per_cnt;
  logic [SW-1:0] lvl_cnt;
  logic [GW-1:0] good_cnt;
  logic [HW-1:0] hold_cnt;
  logic [RW-1:0] rec_cnt;
  logic [TW-1:0] retries;

  wire pwm_rise = pwm_sh[1] & ~pwm_sh[2];
  wire pwm_edge = pwm_sh[1] ^ pwm_sh[2];
  wire in_win   = (per_cnt >= PMIN) && (per_cnt <= PMAX);
  wire stuck    = lvl_cnt > STUCK_LIM;
  wire pwm_ok   = (good_cnt == GOOD_N) && !stuck;
  wire abort    = !gate_ok || pd_req || seq_error;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_sh   <= '0;
      per_cnt  <= '1;
      lvl_cnt  <= '0;
      good_cnt <= '0;
    end else begin
      pwm_sh <= {pwm_sh[1:0], pwm_in};
      if (pwm_rise) per_cnt <= CW'(1);
      else if (per_cnt != '1) per_cnt <= per_cnt + 1'b1;
      if (pwm_edge) lvl_cnt <= '0;
      else if (!stuck) lvl_cnt <= lvl_cnt + 1'b1;
      if (stuck) good_cnt <= '0;
      else if (pwm_rise) begin
        if (!in_win) good_cnt <= '0;
        else if (good_cnt != GOOD_N) good_cnt <= good_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    nstate = state;
    unique case (state)
      S_OFF:     if (!abort) nstate = S_HOLD;
      S_HOLD:    if (abort) nstate = S_OFF;
                 else if (hold_cnt == HOLD_LAST) nstate = S_ARM;
      S_ARM:     if (abort) nstate = S_OFF;
                 else if (mod_ready && pwm_ok) nstate = S_RUN;
      S_RUN:     if (abort) nstate = S_OFF;
                 else if (!stage_ok) nstate = (retries == RETRY_N) ? S_LOCK : S_RECOVER;
                 else if (!mod_ready || !pwm_ok) nstate = S_ARM;
      S_RECOVER: if (abort) nstate = S_OFF;
                 else if (rec_cnt == REC_LAST) nstate = S_ARM;
      S_LOCK:    if (abort) nstate = S_OFF;
      default:   nstate = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_OFF;
      amp_rst_n <= 1'b0;
      hold_cnt  <= '0;
      rec_cnt   <= '0;
      retries   <= '0;
      seq_error <= 1'b0;
    end else begin
      state     <= nstate;
      amp_rst_n <= (nstate == S_RUN);
      hold_cnt  <= (state == S_HOLD) ? hold_cnt + 1'b1 : '0;
      rec_cnt   <= (state == S_RECOVER) ? rec_cnt + 1'b1 : '0;
      if (state == S_OFF) retries <= '0;
      else if (state == S_RUN && nstate == S_RECOVER) retries <= retries + 1'b1;
      if (pwr_ok && !gate_ok) seq_error <= 1'b1;
    end
  end

  assign recovering    = (state == S_RECOVER);
  assign persist_fault = (state == S_LOCK);

endmodule

// File: rtl/amp_reset_sequencer_chk.sv
module amp_reset_sequencer_chk #(
  parameter int HOLD_CYCLES    = 100000,
  parameter int STUCK_CYCLES   = 570,
  parameter int RECOVER_CYCLES = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic gate_ok,
  input logic pwr_ok,
  input logic pwm_in,
  input logic mod_ready,
  input logic pd_req,
  input logic stage_ok,
  input logic amp_rst_n,
  input logic recovering,
  input logic persist_fault,
  input logic seq_error
);

  int   gate_run, stable_run, rec_run;
  logic pwm_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_run   <= 0;
      stable_run <= 0;
      rec_run    <= 0;
      pwm_prev   <= 1'b0;
    end else begin
      pwm_prev <= pwm_in;
      if (!gate_ok) gate_run <= 0;
      else if (gate_run < HOLD_CYCLES + 3) gate_run <= gate_run + 1;
      if (pwm_in != pwm_prev) stable_run <= 0;
      else if (stable_run < STUCK_CYCLES + 20) stable_run <= stable_run + 1;
      rec_run <= recovering ? rec_run + 1 : 0;
    end
  end

  assert_gate_loss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_ok |=> !amp_rst_n);
  assert_hold_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amp_rst_n) |-> gate_run >= HOLD_CYCLES + 2);
  assert_mod_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amp_rst_n) |-> $past(mod_ready));
  assert_stuck_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stable_run > STUCK_CYCLES + 8) |-> !amp_rst_n);
  assert_power_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |=> !amp_rst_n);
  assert_seq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !gate_ok) |=> seq_error);
  assert_seq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_error |-> !amp_rst_n);
  assert_fault_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_rst_n && !stage_ok) |=> !amp_rst_n);
  assert_recover_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(recovering) && $past(gate_ok && !pd_req && !seq_error)) |-> rec_run == RECOVER_CYCLES);
  assert_lock_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    persist_fault |-> (!amp_rst_n && !recovering));

endmodule

bind amp_reset_sequencer amp_reset_sequencer_chk #(
  .HOLD_CYCLES(HOLD_CYCLES),
  .STUCK_CYCLES(STUCK_CYCLES),
  .RECOVER_CYCLES(RECOVER_CYCLES)
) chk_i (.*);

// File: tb/amp_reset_sequencer_tb_top.sv
module amp_reset_sequencer_tb_top;

  localparam int HOLD  = 40;
  localparam int PMIN  = 10;
  localparam int PMAX  = 14;
  localparam int GOOD  = 3;
  localparam int STUCK = 28;
  localparam int RECL  = 8;
  localparam int RETRY = 2;

  logic clk = 1'b0;
  logic rst_n, gate_ok, pwr_ok, pwm_in, mod_ready, pd_req, stage_ok;
  logic amp_rst_n, recovering, persist_fault, seq_error;

  int  per = 12;
  bit  stuck_hi = 1'b0;
  int  errors = 0, checks = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  amp_reset_sequencer #(
    .HOLD_CYCLES(HOLD), .PERIOD_MIN(PMIN), .PERIOD_MAX(PMAX), .GOOD_PERIODS(GOOD),
    .STUCK_CYCLES(STUCK), .RECOVER_CYCLES(RECL), .MAX_RETRIES(RETRY)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .gate_ok(gate_ok), .pwr_ok(pwr_ok), .pwm_in(pwm_in),
    .mod_ready(mod_ready), .pd_req(pd_req), .stage_ok(stage_ok),
    .amp_rst_n(amp_rst_n), .recovering(recovering), .persist_fault(persist_fault),
    .seq_error(seq_error)
  );

  function automatic bit exp_valid(int p);
    return (p >= PMIN) && (p <= PMAX);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic fault_recover(string req);
    int lowc, recc;
    stage_ok = 1'b0;
    @(negedge clk);
    chk(req, "reset low after fault", amp_rst_n, 0);
    chk(req, "recovering raised", recovering, 1);
    lowc = 1; recc = 1;
    stage_ok = 1'b1;
    for (int i = 0; i < 200 && !amp_rst_n; i++) begin
      @(negedge clk);
      if (!amp_rst_n) lowc++;
      if (recovering) recc++;
    end
    chk(req, "recovering cycles", recc, RECL);
    chk(req, "recovery low cycles", lowc, RECL + 1);
  endtask

  initial begin
    pwm_in = 1'b0;
    forever begin
      if (stuck_hi) begin
        pwm_in = 1'b1;
        @(negedge clk);
      end else begin
        int p;
        p = per;
        pwm_in = 1'b1;
        cyc(p / 2);
        pwm_in = 1'b0;
        cyc(p - p / 2);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    int n;
    int plist[4];
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; gate_ok = 1'b0; pwr_ok = 1'b0; mod_ready = 1'b0;
    pd_req = 1'b0; stage_ok = 1'b1;
    cyc(5);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset amp_rst_n", amp_rst_n, 0);
    chk("R1", "reset recovering", recovering, 0);
    chk("R1", "reset persist_fault", persist_fault, 0);
    chk("R1", "reset seq_error", seq_error, 0);
    cyc(60);
    chk("R1", "no gate supply keeps reset low", amp_rst_n, 0);

    // R2 exact hold latency
    gate_ok = 1'b1; mod_ready = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!amp_rst_n && n < 1000);
    chk("R2", "hold release latency", n, HOLD + 2);
    pwr_ok = 1'b1;

    // R6 power-down
    pd_req = 1'b1;
    @(negedge clk);
    chk("R6", "reset low after pd_req", amp_rst_n, 0);
    cyc(20);
    chk("R6", "reset held while pd_req", amp_rst_n, 0);
    pd_req = 1'b0;
    cyc(HOLD);
    chk("R2", "no early release after restart", amp_rst_n, 0);
    cyc(10);
    chk("R2", "release after hold", amp_rst_n, 1);

    // R3 modulator readiness
    pd_req = 1'b1; cyc(2);
    mod_ready = 1'b0; pd_req = 1'b0;
    cyc(HOLD + 50);
    chk("R3", "no release without mod_ready", amp_rst_n, 0);
    mod_ready = 1'b1;
    @(negedge clk);
    chk("R3", "release on mod_ready", amp_rst_n, 1);
    mod_ready = 1'b0;
    @(negedge clk);
    chk("R3", "drop on mod_ready loss", amp_rst_n, 0);
    mod_ready = 1'b1;
    cyc(2);
    chk("R3", "rerelease on mod_ready", amp_rst_n, 1);

    // R4 out-of-window period while running
    per = 20;
    cyc(45);
    chk("R4", "slow period drops reset", amp_rst_n, 0);
    per = 12;
    cyc(80);
    chk("R4", "valid period rereleases", amp_rst_n, 1);

    // R3/R4 window: directed boundaries then random periods
    plist[0] = PMIN - 1; plist[1] = PMIN; plist[2] = PMAX; plist[3] = PMAX + 1;
    for (int t = 0; t < 20; t++) begin
      int p;
      p = (t < 4) ? plist[t] : 6 + int'($urandom_range(14));
      pd_req = 1'b1;
      per = p;
      cyc(60);
      pd_req = 1'b0;
      cyc(HOLD + 160);
      chk("R3", $sformatf("release for period %0d", p), amp_rst_n, int'(exp_valid(p)));
    end
    per = 12;
    pd_req = 1'b1; cyc(2); pd_req = 1'b0;
    cyc(HOLD + 100);
    chk("R3", "running before stuck test", amp_rst_n, 1);

    // R5 stuck high
    stuck_hi = 1'b1;
    cyc(STUCK + 10);
    chk("R5", "stuck-high drops reset", amp_rst_n, 0);
    stuck_hi = 1'b0;
    cyc(100);
    chk("R5", "switching again rereleases", amp_rst_n, 1);

    // R8 recovery and R9 retry limit
    fault_recover("R8");
    fault_recover("R9");
    stage_ok = 1'b0;
    @(negedge clk);
    chk("R9", "lock after retries", persist_fault, 1);
    chk("R9", "reset low in lock", amp_rst_n, 0);
    stage_ok = 1'b1;
    cyc(50);
    chk("R9", "lock persists", persist_fault, 1);
    chk("R9", "reset still low in lock", amp_rst_n, 0);
    pd_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "power-down clears lock", persist_fault, 0);
    pd_req = 1'b0;
    cyc(HOLD + 100);
    chk("R9", "running after lock cleared", amp_rst_n, 1);
    stage_ok = 1'b0;
    @(negedge clk);
    chk("R9", "retry count restarted", recovering, 1);
    stage_ok = 1'b1;
    cyc(RECL + 60);
    chk("R8", "running after recovery", amp_rst_n, 1);

    // R1 clean supply loss
    gate_ok = 1'b0; pwr_ok = 1'b0;
    @(negedge clk);
    chk("R1", "gate loss drops reset", amp_rst_n, 0);
    chk("R7", "no violation on joint drop", seq_error, 0);
    gate_ok = 1'b1; pwr_ok = 1'b1;
    cyc(HOLD + 60);
    chk("R2", "running after supply return", amp_rst_n, 1);

    // R7 sequencing violation
    gate_ok = 1'b0;
    @(negedge clk);
    chk("R7", "violation flagged", seq_error, 1);
    chk("R7", "reset low on violation", amp_rst_n, 0);
    gate_ok = 1'b1;
    cyc(300);
    chk("R7", "violation sticky", seq_error, 1);
    chk("R7", "reset held by violation", amp_rst_n, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7", "system reset clears violation", seq_error, 0);
    cyc(HOLD + 20);
    chk("R7", "release after clearing", amp_rst_n, 1);

    summary();
  end

endmodule